// File: doc/BRIEF.md
# Event Counter Bank for a Processor Core

This block holds a small set of 32-bit event counters that software programs through a word-addressed register port. A processor pipeline presents its events as bit vectors of 16 bits each, one vector per event group, together with the current privilege level. Each counter has its own control word. The control word picks one group, gives a 16-bit subevent mask, and sets a privilege qualifier. While the master enable is set, the counter advances by one in every cycle in which at least one masked subevent of its group is active.

To measure a period, software loads the two's complement of the period into a counter. The counter sets its overflow flag when it wraps from all ones to zero. If the interrupt enable in its control word is set, the flag also drives the single interrupt output. One select code turns a counter into the upper half of a cascade: it then counts the wraps of the counter below it, in the same cycle as each wrap. Software clears an overflow by writing back the status word it has just read.

Top module: `pmc_bank`

## Requirements
- R1: The register addresses are as follows. Global control is at 0x1000. Counter i has its value at 0x1080+4i, its control at 0x1100+4i and its status at 0x1180+4i, for i below NUM_CNT. A read of any other address, or of an address that is not word-aligned, returns 0. All registers read 0 after reset.
- R2: Bit 0 of global control is the master enable, and the other bits of that register read 0. While the enable is 0, no counter value changes except through a software write.
- R3: The control word has these fields: bit 0 interrupt enable, bit 3 privilege override, bits 7:4 trace level, bits 12:8 group select, bits 31:16 subevent mask. All other bits read 0. For a group code g other than 1, the group vector is ev_bits[16g+15:16g], or all zeros when g is NUM_GROUPS or above. The counter adds 1 in a cycle when (vector AND mask) is nonzero, and never adds more than 1 in a cycle.
- R4: An event-driven count happens only when priv_lvl is less than or equal to the trace level, or when the privilege override bit is set.
- R5: Group code 1 chains counter i to counter i-1. Counter i then adds 1 in the same clock edge at which counter i-1 wraps. It ignores the event vectors and the privilege qualifier, but it still needs the master enable. Counter 0 with code 1 never counts.
- R6: A write to a counter value loads the written word. It takes precedence over an increment in the same cycle, and that cycle then produces no wrap.
- R7: An increment from 0xFFFFFFFF yields 0 and sets the overflow flag, which is status bit 0. If a wrap and a clearing write fall in the same cycle, the flag stays set.
- R8: Writing status with bit 0 set clears the overflow flag. Writing a 0 there leaves it unchanged, and all other status bits are read-only. Writing back the value just read therefore clears a pending overflow.
- R9: Status bit 4 reads as the overflow flag ANDed with the interrupt enable. The irq output is the OR of bit 4 across all counters. The other status bits read 0.
- R10: After a control write of zero, the counter holds its value under any events, and its overflow no longer reaches irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address for both read and write |
| reg_we | input | 1 | Write strobe, taken at the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ev_bits | input | 16*NUM_GROUPS | Subevent vectors, group g at bits 16g+15:16g |
| priv_lvl | input | 4 | Current privilege level |
| irq | output | 1 | Aggregated counter interrupt |

## Verification
Several event patterns are checked. A steady cycle event alone shows the basic count rate. Sparse random vectors over all groups, with random masks, separate the masked match from an unmasked one and the selected group from its neighbours. Select codes beyond the implemented groups confirm that those groups stay silent. Sweeping the privilege level across the trace level, with and without the override, pins down the qualifier boundary. Preloads just below the wrap point, combined with cascaded counters, write collisions and clears that coincide with a wrap, show that each precedence rule and the same-edge cascade hold.

// File: rtl/pmc_pkg.sv
`timescale 1ns/10ps
package pmc_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SUB_W   = 16;
  localparam int unsigned SEL_W   = 5;
  localparam int unsigned LVL_W   = 4;
  localparam int unsigned SEL_MAX = 1 << SEL_W;

  localparam logic [SEL_W-1:0] SEL_CHAIN = 5'd1;

  localparam int unsigned GLB_ADDR = 32'h1000;
  localparam int unsigned VAL_BASE = 32'h1080;
  localparam int unsigned CTL_BASE = 32'h1100;
  localparam int unsigned STA_BASE = 32'h1180;

  typedef struct packed {
    logic [SUB_W-1:0] mask;
    logic [SEL_W-1:0] grp;
    logic [LVL_W-1:0] trace_lvl;
    logic             kern;
    logic             irq_en;
  } pmc_ctrl_t;

  function automatic pmc_ctrl_t ctrl_unpack(input logic [DATA_W-1:0] w);
    pmc_ctrl_t c;
    c.mask      = w[31:16];
    c.grp       = w[12:8];
    c.trace_lvl = w[7:4];
    c.kern      = w[3];
    c.irq_en    = w[0];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_pack(input pmc_ctrl_t c);
    return {c.mask, 3'b000, c.grp, c.trace_lvl, c.kern, 2'b00, c.irq_en};
  endfunction

  function automatic logic [DATA_W-1:0] stat_pack(input logic ovf, input logic irq_bit);
    return {27'd0, irq_bit, 3'b000, ovf};
  endfunction

  function automatic logic priv_ok(input pmc_ctrl_t c, input logic [LVL_W-1:0] lvl);
    return c.kern | (lvl <= c.trace_lvl);
  endfunction

  function automatic logic [DATA_W-1:0] cnt_next(input logic [DATA_W-1:0] v);
    return v + 32'd1;
  endfunction

  function automatic logic cnt_at_top(input logic [DATA_W-1:0] v);
    return &v;
  endfunction

endpackage

// File: rtl/pmc_event_match.sv
`timescale 1ns/10ps
module pmc_event_match
  import pmc_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 16
) (
  input  logic [NUM_GROUPS*SUB_W-1:0] ev_bits,
  input  logic [SEL_W-1:0]            grp,
  input  logic [SUB_W-1:0]            mask,
  output logic                        hit
);

  logic [SEL_MAX-1:0] grp_hit;

  for (genvar g = 0; g < SEL_MAX; g++) begin : g_grp
    if (g < NUM_GROUPS) begin : g_real
      assign grp_hit[g] = |(ev_bits[g*SUB_W +: SUB_W] & mask);
    end else begin : g_absent
      assign grp_hit[g] = 1'b0;
    end
  end

  assign hit = grp_hit[grp];

endmodule

// File: rtl/pmc_counter.sv
`timescale 1ns/10ps
module pmc_counter
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              ev_hit,
  input  logic              chain_in,
  input  logic [LVL_W-1:0]  priv,
  input  logic              wr_val,
  input  logic              wr_ctl,
  input  logic              wr_sta,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value_o,
  output pmc_ctrl_t         ctrl_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              wrap_o
);

  logic sel_chain;
  logic count_req;
  logic inc_go;
  logic ovf_clr;

  assign sel_chain = (ctrl_o.grp == SEL_CHAIN);
  assign count_req = glb_en & (sel_chain ? chain_in : (ev_hit & priv_ok(ctrl_o, priv)));
  assign inc_go    = count_req & ~wr_val;
  assign wrap_o    = inc_go & cnt_at_top(value_o);
  assign ovf_clr   = wr_sta & wdata[0];
  assign irq_o     = ovf_o & ctrl_o.irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_o <= '0;
    end else if (wr_val) begin
      value_o <= wdata;
    end else if (inc_go) begin
      value_o <= cnt_next(value_o);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o <= '0;
    end else if (wr_ctl) begin
      ctrl_o <= ctrl_unpack(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_o <= 1'b0;
    end else if (wrap_o) begin
      ovf_o <= 1'b1;
    end else if (ovf_clr) begin
      ovf_o <= 1'b0;
    end
  end

  p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !wr_val) |=> $stable(value_o));

  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_val |=> (value_o == $past(value_o)) || (value_o == $past(value_o) + 32'd1));

  p_chain_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_chain && chain_in && glb_en && !wr_val) |=> value_o == $past(value_o) + 32'd1);

  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_val |=> value_o == $past(wdata));

  p_wrap_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (ovf_o && value_o == '0));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !(wr_sta && wdata[0])) |=> ovf_o);

endmodule

// File: rtl/pmc_bank.sv
`timescale 1ns/10ps
module pmc_bank
  import pmc_pkg::*;
#(
  parameter int unsigned NUM_CNT    = 4,
  parameter int unsigned NUM_GROUPS = 16,
  parameter int unsigned ADDR_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic                        reg_we,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic [NUM_GROUPS*SUB_W-1:0] ev_bits,
  input  logic [LVL_W-1:0]            priv_lvl,
  output logic                        irq
);

  localparam int unsigned BLK_W = ADDR_W - 7;
  localparam logic [BLK_W-1:0] VAL_BLK = BLK_W'(VAL_BASE >> 7);
  localparam logic [BLK_W-1:0] CTL_BLK = BLK_W'(CTL_BASE >> 7);
  localparam logic [BLK_W-1:0] STA_BLK = BLK_W'(STA_BASE >> 7);

  logic              glb_en;
  logic              aligned;
  logic [BLK_W-1:0]  blk;
  logic [4:0]        cidx;
  logic              cidx_ok;
  logic              sel_glb, sel_val, sel_ctl, sel_sta;

  logic [DATA_W-1:0] value_v [NUM_CNT];
  pmc_ctrl_t         ctrl_v  [NUM_CNT];
  logic [NUM_CNT-1:0] ovf_v, irq_v, wrap_v, chain_v, hit_v, inten_v;
  logic [NUM_CNT-1:0] wr_val_v, wr_ctl_v, wr_sta_v;

  assign aligned = (reg_addr[1:0] == 2'b00);
  assign blk     = reg_addr[ADDR_W-1:7];
  assign cidx    = reg_addr[6:2];
  assign cidx_ok = ({1'b0, cidx} < 6'(NUM_CNT));
  assign sel_glb = (reg_addr == ADDR_W'(GLB_ADDR));
  assign sel_val = aligned & cidx_ok & (blk == VAL_BLK);
  assign sel_ctl = aligned & cidx_ok & (blk == CTL_BLK);
  assign sel_sta = aligned & cidx_ok & (blk == STA_BLK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en <= 1'b0;
    end else if (reg_we && sel_glb) begin
      glb_en <= reg_wdata[0];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign wr_val_v[i] = reg_we & sel_val & (cidx == 5'(i));
    assign wr_ctl_v[i] = reg_we & sel_ctl & (cidx == 5'(i));
    assign wr_sta_v[i] = reg_we & sel_sta & (cidx == 5'(i));
    assign inten_v[i]  = ctrl_v[i].irq_en;

    if (i == 0) begin : g_head
      assign chain_v[i] = 1'b0;
    end else begin : g_link
      assign chain_v[i] = wrap_v[i-1];
    end

    pmc_event_match #(
      .NUM_GROUPS (NUM_GROUPS)
    ) u_match (
      .ev_bits (ev_bits),
      .grp     (ctrl_v[i].grp),
      .mask    (ctrl_v[i].mask),
      .hit     (hit_v[i])
    );

    pmc_counter u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .glb_en   (glb_en),
      .ev_hit   (hit_v[i]),
      .chain_in (chain_v[i]),
      .priv     (priv_lvl),
      .wr_val   (wr_val_v[i]),
      .wr_ctl   (wr_ctl_v[i]),
      .wr_sta   (wr_sta_v[i]),
      .wdata    (reg_wdata),
      .value_o  (value_v[i]),
      .ctrl_o   (ctrl_v[i]),
      .ovf_o    (ovf_v[i]),
      .irq_o    (irq_v[i]),
      .wrap_o   (wrap_v[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_glb) begin
      reg_rdata = {31'd0, glb_en};
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      if (cidx == 5'(i)) begin
        if (sel_val) reg_rdata = value_v[i];
        if (sel_ctl) reg_rdata = ctrl_pack(ctrl_v[i]);
        if (sel_sta) reg_rdata = stat_pack(ovf_v[i], irq_v[i]);
      end
    end
  end

  assign irq = |irq_v;

  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_glb || sel_val || sel_ctl || sel_sta) |-> reg_rdata == '0);

  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !reg_we) |=> $stable(irq));

  p_irq_after_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(wrap_v & inten_v)) && !reg_we) |=> irq);

  p_ctrl_zero_mute_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && sel_ctl && reg_wdata == '0 && !(|(ovf_v & inten_v & ~wr_ctl_v))) |=> !irq);

endmodule

// File: tb/pmc_bank_tb.sv
`timescale 1ns/10ps
module pmc_bank_tb;

  localparam int N   = 4;
  localparam int G   = 16;
  localparam int EVW = G * 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [15:0]      reg_addr = '0;
  logic             reg_we = 1'b0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [EVW-1:0]   ev_bits = '0;
  logic [3:0]       priv_lvl = '0;
  logic             irq;

  always #2.5 clk = ~clk;

  pmc_bank #(.NUM_CNT(N), .NUM_GROUPS(G), .ADDR_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_bits(ev_bits),
    .priv_lvl(priv_lvl), .irq(irq)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] m_val [N];
  logic [31:0] m_ctl [N];
  logic        m_ovf [N];
  logic        m_glb;

  function automatic logic [31:0] ctl_view(input logic [31:0] w);
    return w & 32'hFFFF_1FF9;
  endfunction

  function automatic bit is_val(input logic [15:0] a, input int i);
    return a == 16'(32'h1080 + 4 * i);
  endfunction
  function automatic bit is_ctl(input logic [15:0] a, input int i);
    return a == 16'(32'h1100 + 4 * i);
  endfunction
  function automatic bit is_sta(input logic [15:0] a, input int i);
    return a == 16'(32'h1180 + 4 * i);
  endfunction

  function automatic bit ev_match(input logic [EVW-1:0] ev, input logic [31:0] ctl);
    int g = int'(ctl[12:8]);
    logic [15:0] v;
    if (g >= G) return 1'b0;
    v = ev[g*16 +: 16];
    return (v & ctl[31:16]) != 16'h0;
  endfunction

  function automatic bit qual_ok(input logic [31:0] ctl, input logic [3:0] pr);
    return ctl[3] || (int'(pr) <= int'(ctl[7:4]));
  endfunction

  function automatic logic [31:0] exp_stat(input int i);
    logic b4;
    b4 = m_ovf[i] & m_ctl[i][0];
    return {27'd0, b4, 3'd0, m_ovf[i]};
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int i = 0; i < N; i++) r |= m_ovf[i] & m_ctl[i][0];
    return r;
  endfunction

  task automatic model_step(input bit we, input logic [15:0] a, input logic [31:0] d,
                            input logic [EVW-1:0] ev, input logic [3:0] pr);
    bit inc_n [N];
    bit wrap_n [N];
    for (int i = 0; i < N; i++) begin
      bit wr_this = we && is_val(a, i);
      bit inc;
      if (m_ctl[i][12:8] == 5'd1) inc = m_glb && (i > 0) && wrap_n[(i > 0) ? i-1 : 0];
      else inc = m_glb && ev_match(ev, m_ctl[i]) && qual_ok(m_ctl[i], pr);
      inc_n[i]  = inc && !wr_this;
      wrap_n[i] = inc_n[i] && (m_val[i] == 32'hFFFF_FFFF);
    end
    for (int i = 0; i < N; i++) begin
      if (we && is_val(a, i)) m_val[i] = d;
      else if (inc_n[i]) m_val[i] = m_val[i] + 32'd1;
      if (we && is_ctl(a, i)) m_ctl[i] = ctl_view(d);
      if (wrap_n[i]) m_ovf[i] = 1'b1;
      else if (we && is_sta(a, i) && d[0]) m_ovf[i] = 1'b0;
    end
    if (we && a == 16'h1000) m_glb = d[0];
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.2;
    d = reg_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    rd(16'h1000, d); chk(req, "global", d, {31'd0, m_glb});
    for (int i = 0; i < N; i++) begin
      rd(16'(32'h1080 + 4*i), d); chk(req, $sformatf("value%0d", i), d, m_val[i]);
      rd(16'(32'h1100 + 4*i), d); chk(req, $sformatf("ctrl%0d", i), d, m_ctl[i]);
      rd(16'(32'h1180 + 4*i), d); chk(req, $sformatf("status%0d", i), d, exp_stat(i));
    end
    chk(req, "irq", {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  task automatic cyc(input bit we, input logic [15:0] a, input logic [31:0] d,
                     input logic [EVW-1:0] ev, input logic [3:0] pr);
    reg_we = we; reg_addr = a; reg_wdata = d; ev_bits = ev; priv_lvl = pr;
    model_step(we, a, d, ev, pr);
    @(posedge clk);
    #1;
    reg_we = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, '0, 4'd0);
  endtask

  function automatic logic [EVW-1:0] ev_one(input int g, input int b);
    logic [EVW-1:0] e = '0;
    e[g*16 + b] = 1'b1;
    return e;
  endfunction

  initial begin
    logic [31:0] d;
    logic [EVW-1:0] cyc_ev;
    for (int i = 0; i < N; i++) begin
      m_val[i] = '0; m_ctl[i] = '0; m_ovf[i] = 1'b0;
    end
    m_glb = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state and unmapped reads
    check_all("R1");
    rd(16'h1004, d); chk("R1", "unmapped 0x1004", d, 32'h0);
    rd(16'h1090, d); chk("R1", "absent counter value", d, 32'h0);
    rd(16'h1081, d); chk("R1", "unaligned read", d, 32'h0);
    rd(16'h1200, d); chk("R1", "beyond status block", d, 32'h0);
    rd(16'h0000, d); chk("R1", "address zero", d, 32'h0);

    // R3: reserved control bits read zero; R2: global register only bit 0
    wr(16'h1100, 32'hFFFF_FFFF);
    wr(16'h1000, 32'hFFFF_FFFE);
    check_all("R3");

    // R2: counting blocked while master enable clear
    wr(16'h1100, 32'h0001_00F1);
    repeat (3) cyc(1'b0, 16'h0, 32'h0, ev_one(0, 0), 4'd0);
    check_all("R2");
    wr(16'h1000, 32'h1);
    repeat (5) cyc(1'b0, 16'h0, 32'h0, ev_one(0, 0), 4'd0);
    check_all("R3");
    // R3: unmasked subevent and neighbouring group do not count
    repeat (2) cyc(1'b0, 16'h0, 32'h0, ev_one(0, 1) | ev_one(1, 0), 4'd0);
    check_all("R3");

    // R4: privilege qualifier at its boundary
    wr(16'h1104, 32'h00F0_0220);
    cyc(1'b0, 16'h0, 32'h0, ev_one(2, 5), 4'd3);
    check_all("R4");
    cyc(1'b0, 16'h0, 32'h0, ev_one(2, 5), 4'd2);
    check_all("R4");
    wr(16'h1104, 32'h00F0_0228);
    cyc(1'b0, 16'h0, 32'h0, ev_one(2, 4), 4'd15);
    check_all("R4");

    // R5/R7/R9: chain counter 1 to counter 0 across a wrap
    wr(16'h1104, 32'h0000_0100);
    cyc(1'b1, 16'h1080, 32'hFFFF_FFFE, ev_one(0, 0), 4'd0);
    check_all("R6");
    cyc(1'b0, 16'h0, 32'h0, ev_one(0, 0), 4'd0);
    check_all("R7");
    cyc(1'b0, 16'h0, 32'h0, ev_one(0, 0), 4'd0);
    check_all("R5");
    chk("R9", "irq after wrap", {31'd0, irq}, 32'd1);
    // R5: counter 0 on chain code never counts
    wr(16'h1100, 32'h0000_0100);
    repeat (2) cyc(1'b0, 16'h0, 32'h0, ev_one(1, 0) | ev_one(0, 0), 4'd0);
    check_all("R5");
    wr(16'h1100, 32'h0001_00F1);

    // R8: write zero leaves flag, write-back clears
    wr(16'h1180, 32'h0);
    check_all("R8");
    rd(16'h1180, d);
    wr(16'h1180, d);
    check_all("R8");

    // R7: wrap coincides with clearing write
    wr(16'h1080, 32'hFFFF_FFFF);
    cyc(1'b1, 16'h1180, 32'h11, ev_one(0, 0), 4'd0);
    check_all("R7");

    // R6: value write collides with event
    cyc(1'b1, 16'h1080, 32'h0000_0100, ev_one(0, 0), 4'd0);
    check_all("R6");

    // R10: zero control stops counting and masks irq
    wr(16'h1100, 32'h0);
    repeat (3) cyc(1'b0, 16'h0, 32'h0, {EVW{1'b1}}, 4'd0);
    check_all("R10");
    chk("R10", "irq masked", {31'd0, irq}, 32'd0);

    // Random phase: R3 R4 R5 R6 R7 R8 R9
    for (int n = 0; n < 3000; n++) begin
      bit we = ($urandom % 4) == 0;
      logic [15:0] a = 16'h0;
      logic [31:0] dd = 32'h0;
      logic [3:0] pr = 4'($urandom % 16);
      int pick = int'($urandom % 14);
      for (int g = 0; g < G; g++) cyc_ev[g*16 +: 16] = 16'($urandom & $urandom & $urandom);
      cyc_ev[0] = ($urandom % 4) != 0;
      if (pick == 0) begin
        a = 16'h1000; dd = {31'd0, ($urandom % 8) != 0};
      end else if (pick <= 4) begin
        a = 16'(32'h1080 + 4*(pick-1));
        dd = ($urandom % 2) ? (32'hFFFF_FFF0 + ($urandom % 16)) : $urandom;
      end else if (pick <= 8) begin
        int s = ($urandom % 6 == 0) ? 20 + int'($urandom % 12) : int'($urandom % 5);
        a = 16'(32'h1100 + 4*(pick-5));
        dd = {16'($urandom), 3'($urandom), 5'(s), 4'($urandom), 4'($urandom)};
      end else if (pick <= 12) begin
        a = 16'(32'h1180 + 4*(pick-9));
        dd = ($urandom % 2) ? 32'h11 : 32'($urandom % 2);
      end else begin
        a = 16'(32'h1000 + ($urandom % 512)); dd = $urandom;
      end
      cyc(we, a, dd, cyc_ev, pr);
      check_all("R3");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule